// File: doc/BRIEF.md
# External Bus Read Controller

This block runs read accesses on an external parallel memory bus. After a request is accepted, it drives a zone select and the address. It then moves through three timed phases, counted in cycles of the bus-timing clock: a lead phase with the select alone, an active phase with the read strobe also low, and a trail phase with the strobe released and the select still held. The phase lengths are given with each request and latched when the request is accepted.

An external ready input can stretch the active phase. A mode input picks one of two paths for it. In synchronous mode the ready pin passes through one register. In asynchronous mode it passes through a two-flop synchronizer, so its samples are taken one edge earlier. In both modes the strobe ends at the same edge when ready is found high at the first sample. Each sample found low adds exactly one more active cycle, and ready is then checked again on the next edge.

Read data is captured on the edge where the strobe goes inactive. A one-cycle done pulse follows the trail phase. The address outputs are never cleared: they keep the last address between accesses.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o and rd_n_o are 1, done_o is 0, and addr_o and data_o are 0.
- R2: A request (req_i high at a rising edge) is accepted only while the controller is idle. The edge that accepts it starts access cycle 0: cs_n_o goes low and addr_o takes addr_i. A request raised while an access is running is ignored: it changes neither addr_o nor the timing, and it starts no access afterwards.
- R3: The lead phase lasts exactly lead_i cycles (lead_i of at least 1), with cs_n_o low and rd_n_o high.
- R4: Synchronous mode (async_rdy_i = 0): rd_n_o stays low for active_i cycles plus wait cycles. The first ready sample is the level rdy_i holds at the edge that begins the last active cycle, that is, edge lead_i + active_i - 1 counted from the accepting edge as edge 0.
- R5: Asynchronous mode (async_rdy_i = 1, active_i of at least 2): the first ready sample is the level on rdy_i one edge earlier, at edge lead_i + active_i - 2. When ready is high at that sample, the strobe is released at the same edge as in synchronous mode.
- R6: Each ready sample found low adds exactly one active cycle, and the next sample is taken one edge later. With k low samples in a row before a high one, rd_n_o is low for active_i + k cycles.
- R7: After the strobe is released, cs_n_o stays low for exactly trail_i cycles (at least 1) with rd_n_o high.
- R8: done_o is high for exactly one cycle: the first cycle with cs_n_o high after the trail, which is access cycle lead_i + active_i + k + trail_i.
- R9: data_o takes rdata_i at the edge where rd_n_o goes from low to high, and holds that value until the next such edge.
- R10: While the bus is idle, addr_o keeps the last address driven and is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-timing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request, taken only while idle |
| addr_i | input | AW | Address for the requested read |
| lead_i | input | CW | Lead phase length in cycles, at least 1 |
| active_i | input | CW | Active phase length in cycles, at least 1 (at least 2 in asynchronous mode) |
| trail_i | input | CW | Trail phase length in cycles, at least 1 |
| async_rdy_i | input | 1 | 1: ready passes through the two-flop synchronizer; 0: ready is registered once |
| rdy_i | input | 1 | External ready from the bus |
| rdata_i | input | DW | Read data from the bus |
| cs_n_o | output | 1 | Zone select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| addr_o | output | AW | Address bus, held between accesses |
| data_o | output | DW | Captured read data |
| done_o | output | 1 | One-cycle pulse after the trail phase |

## Verification
The hardest case to reach is ready arriving exactly at a chosen sample. The number of wait cycles depends on the level rdy_i has at a particular edge, and that edge differs between the two modes. The bench works out each access's first sample edge from the lead and active lengths and the mode. It then drives rdy_i low for exactly k sample edges and high from the next one, with k set to 0, 1 and several, and counts the strobe cycles it sees against active_i + k. Read data on the bus is valid only while the strobe is low and random otherwise, so a capture taken one edge too early or too late gives a wrong value.

// File: rtl/xbr_pkg.sv
// Shared types for the external bus read controller.
package xbr_pkg;
    // Access sequencer states
    typedef enum logic [1:0] {
        XB_IDLE  = 2'd0,
        XB_LEAD  = 2'd1,
        XB_ACT   = 2'd2,
        XB_TRAIL = 2'd3
    } xb_state_e;
endpackage

// File: rtl/xbr_rdy_cond.sv
// Ready conditioning: a shift chain of SYNC_STAGES flops on the ready pin.
// Synchronous mode taps the first flop (one register delay). Asynchronous
// mode taps the last flop (full synchronizer). Assumes SYNC_STAGES >= 2.
module xbr_rdy_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_i,
    input  logic async_i,
    output logic rdy_c_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sh_q;

    // First stage captures the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= rdy_i;
    end

    // Later stages form the synchronizer chain
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
        end
    end

    // Mode picks the tap
    assign rdy_c_o = async_i ? sh_q[LAST] : sh_q[0];
endmodule

// File: rtl/xbr_phase_seq.sv
// Phase sequencer: lead, active (stretched by ready) and trail, counted in
// clock cycles with one down counter. Lengths are latched at start and are
// assumed to be >= 1. release_o marks the edge that ends the strobe.
module xbr_phase_seq
    import xbr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] lead_i,
    input  logic [CW-1:0] act_i,
    input  logic [CW-1:0] trail_i,
    input  logic          rdy_c_i,
    output xb_state_e     state_o,
    output logic          release_o,
    output logic          done_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    xb_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] act_q;
    logic [CW-1:0] trail_q;
    logic          last_w;

    assign last_w    = (cnt_q == '0);
    assign release_o = (st_q == XB_ACT) && last_w && rdy_c_i;
    assign state_o   = st_q;

    // State, counter and latched lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= XB_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            trail_q <= '0;
        end else begin
            unique case (st_q)
                XB_IDLE: if (start_i) begin
                    st_q    <= XB_LEAD;
                    cnt_q   <= lead_i - ONE;
                    act_q   <= act_i;
                    trail_q <= trail_i;
                end
                XB_LEAD: if (last_w) begin
                    st_q  <= XB_ACT;
                    cnt_q <= act_q - ONE;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
                XB_ACT: if (!last_w) begin
                    cnt_q <= cnt_q - ONE;
                end else if (rdy_c_i) begin
                    st_q  <= XB_TRAIL;
                    cnt_q <= trail_q - ONE;
                end
                XB_TRAIL: if (last_w) begin
                    st_q <= XB_IDLE;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
                default: st_q <= XB_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse after the trail phase
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (st_q == XB_TRAIL) && last_w;
    end
endmodule

// File: rtl/xbus_rd_ctrl.sv
// External bus read controller top. Accepts a request while idle, drives
// select, strobe and a held address, and captures read data at the edge
// where the strobe is released. Assumes lengths >= 1, active >= 2 in
// asynchronous ready mode.
module xbus_rd_ctrl
    import xbr_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] lead_i,
    input  logic [CW-1:0] active_i,
    input  logic [CW-1:0] trail_i,
    input  logic          async_rdy_i,
    input  logic          rdy_i,
    input  logic [DW-1:0] rdata_i,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          done_o
);
    xb_state_e     st_w;
    logic          rdy_c_w;
    logic          release_w;
    logic          accept_w;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign accept_w = req_i && (st_w == XB_IDLE);

    xbr_rdy_cond #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_i   (rdy_i),
        .async_i (async_rdy_i),
        .rdy_c_o (rdy_c_w)
    );

    xbr_phase_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept_w),
        .lead_i    (lead_i),
        .act_i     (active_i),
        .trail_i   (trail_i),
        .rdy_c_i   (rdy_c_w),
        .state_o   (st_w),
        .release_o (release_w),
        .done_o    (done_o)
    );

    // Address register: loaded on accept only, otherwise held
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (accept_w) addr_q <= addr_i;
    end

    // Data capture at the strobe release edge
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (release_w) data_q <= rdata_i;
    end

    assign cs_n_o = (st_w == XB_IDLE);
    assign rd_n_o = (st_w != XB_ACT);
    assign addr_o = addr_q;
    assign data_o = data_q;
endmodule

// File: rtl/xbr_chk.sv
// Assertion checker for xbus_rd_ctrl, attached with bind below.
module xbr_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] data,
    input logic          done
);
    // R4: the strobe is only ever low inside the select window
    a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    // R3: the strobe falls only after at least one lead cycle
    a_r3_lead_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(cs_n));

    // R7: the strobe release is followed by trail cycles with select held
    a_r7_trail_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !cs_n);

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done comes in the first idle cycle after the select
    a_r8_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    // R10: address changes only when a new access starts
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cs_n) && !cs_n) |-> $stable(addr));

    // R9: data changes only at a strobe release edge
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_n && !$past(rd_n)) |-> $stable(data));
endmodule

bind xbus_rd_ctrl xbr_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n_o),
    .rd_n  (rd_n_o),
    .addr  (addr_o),
    .data  (data_o),
    .done  (done_o)
);

// File: tb/sim_xbus_rd_ctrl.sv
module sim_xbus_rd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] lead_i = 4'd1;
    logic [CW-1:0] active_i = 4'd2;
    logic [CW-1:0] trail_i = 4'd1;
    logic          async_rdy_i = 1'b0;
    logic          rdy_i = 1'b0;
    logic [DW-1:0] rdata_i = '0;
    logic          cs_n_o;
    logic          rd_n_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_o;
    logic          done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_rd_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .lead_i(lead_i), .active_i(active_i), .trail_i(trail_i),
        .async_rdy_i(async_rdy_i), .rdy_i(rdy_i), .rdata_i(rdata_i),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .addr_o(addr_o),
        .data_o(data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected strobe length: active cycles plus one per low ready sample
    function automatic int exp_active(input int a, input int k);
        return a + k;
    endfunction

    // Edge index (from the accepting edge) of the first ready sample
    function automatic int first_sample(input int l, input int a, input bit am);
        return am ? (l + a - 2) : (l + a - 1);
    endfunction

    task automatic do_access(input int l, input int a, input int t, input bit am,
                             input int k, input logic [AW-1:0] ad,
                             input logic [DW-1:0] dv, input bit poke);
        int s;
        int c;
        int lc;
        int ac;
        int tc;
        int done_c;
        logic [DW-1:0] prev;
        s = first_sample(l, a, am);
        prev = data_o;
        @(negedge clk);
        lead_i = CW'(l); active_i = CW'(a); trail_i = CW'(t);
        async_rdy_i = am; rdy_i = 1'b0; req_i = 1'b1; addr_i = ad;
        rdata_i = DW'($urandom);
        @(negedge clk);
        req_i = 1'b0; addr_i = AW'($urandom);
        c = 0; lc = 0; ac = 0; tc = 0; done_c = -1;
        while (c < 400) begin
            if (c == 0) chk(cs_n_o == 1'b0, "R2 select low in cycle 0", cs_n_o, 0);
            if (!cs_n_o && rd_n_o && ac == 0) lc++;
            else if (!rd_n_o) ac++;
            else if (!cs_n_o) tc++;
            if (!cs_n_o) begin
                if (addr_o != ad) chk(1'b0, "R2 address during access", addr_o, ad);
                if (tc == 0 && data_o != prev) chk(1'b0, "R9 data held before release", data_o, prev);
                if (tc > 0 && data_o != dv) chk(1'b0, "R9 data after release", data_o, dv);
            end
            if (done_o) begin
                done_c = c;
                break;
            end
            rdy_i = ((c + 1) >= (s + k));
            rdata_i = (!rd_n_o) ? dv : DW'($urandom);
            if (poke && c == 1) begin req_i = 1'b1; addr_i = ~ad; end
            if (poke && c == 2) req_i = 1'b0;
            @(negedge clk);
            c++;
        end
        chk(lc == l, "R3 lead length", lc, l);
        if (k > 0) chk(ac == exp_active(a, k), "R6 wait cycles", ac, exp_active(a, k));
        else if (am) chk(ac == exp_active(a, k), "R5 async active length", ac, exp_active(a, k));
        else chk(ac == exp_active(a, k), "R4 sync active length", ac, exp_active(a, k));
        chk(tc == t, "R7 trail length", tc, t);
        chk(done_c == l + a + k + t, "R8 done cycle", done_c, l + a + k + t);
        chk(cs_n_o == 1'b1, "R8 select high with done", cs_n_o, 1);
        chk(data_o == dv, "R9 captured data", data_o, dv);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        chk(cs_n_o == 1'b1, "R2 no access from ignored request", cs_n_o, 1);
        chk(addr_o == ad, "R10 address held while idle", addr_o, ad);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 reset select", cs_n_o, 1);
        chk(rd_n_o == 1'b1, "R1 reset strobe", rd_n_o, 1);
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);
        chk(addr_o == '0, "R1 reset address", addr_o, 0);
        chk(data_o == '0, "R1 reset data", data_o, 0);
        // Directed: each mode with 0, 1 and several low samples
        do_access(2, 3, 2, 1'b0, 0, 16'h1111, 16'hA001, 1'b0);
        do_access(2, 3, 2, 1'b0, 1, 16'h2222, 16'hA002, 1'b0);
        do_access(2, 3, 2, 1'b0, 5, 16'h3333, 16'hA003, 1'b1);
        do_access(1, 2, 1, 1'b1, 0, 16'h4444, 16'hA004, 1'b0);
        do_access(1, 2, 1, 1'b1, 1, 16'h5555, 16'hA005, 1'b0);
        do_access(3, 4, 2, 1'b1, 6, 16'h6666, 16'hA006, 1'b1);
        do_access(1, 1, 1, 1'b0, 0, 16'h7777, 16'hA007, 1'b0);
        // R10: several idle cycles keep the address
        repeat (5) @(negedge clk);
        chk(addr_o == 16'h7777, "R10 address after idle gap", addr_o, 16'h7777);
        // Random accesses
        for (int i = 0; i < 40; i++) begin
            bit am;
            int l;
            int a;
            int t;
            int k;
            am = 1'($urandom);
            l = 1 + int'($urandom % 6);
            a = (am ? 2 : 1) + int'($urandom % 6);
            t = 1 + int'($urandom % 4);
            k = int'($urandom % 5);
            do_access(l, a, t, am, k, AW'($urandom), DW'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 run did not complete actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule